// File: doc/BRIEF.md
# Relative-Jump Accumulator Core

This block is a small processor with one accumulator and one memory that holds both program and data. It has no conditional branch. Every instruction word carries a two-bit operation code and a signed offset, and every operand or jump target is found by adding that offset to the address of the instruction being executed. The four operations are an unconditional relative jump, a load into the accumulator, a store from the accumulator, and an accumulator increment.

Programs make decisions by storing a computed value into a code slot and then executing it. Because the jump code is all zeros, the data word 0 runs as a jump to itself and the data word 1 runs as a jump to the following word. A small counter value can therefore pick one of several nearby jumps. A program can also end a copy loop by overwriting one of its own instructions.

The core drives one synchronous memory port, whose read data arrives one clock after the address. It also exposes the program counter, the accumulator, and a flag that is set once the program sits in a jump-to-self.

Top module: `rjc_core`

## Requirements
- R1: An instruction word places the operation in its two top bits, with jump = 00, load = 01, store = 10 and increment = 11. The low DATA_W-2 bits hold a two's-complement offset.
- R2: The effective address is the current instruction address plus the sign-extended offset, taken modulo 2^ADDR_W. It wraps at both ends of memory.
- R3: A jump sets the program counter to the effective address. The data word 0 executes as a jump to itself, and the data word 1 executes as a jump to the next word.
- R4: A load copies the memory word at the effective address into the accumulator.
- R5: A store writes the accumulator to the effective address. `mem_we` is high for exactly one cycle per store and low at all other times.
- R6: An increment adds one to the accumulator modulo 2^DATA_W, whatever value its offset field holds.
- R7: A word written by a store executes with its new contents the next time it is fetched.
- R8: `parked` rises after a jump with a zero offset executes. It stays high while that jump repeats, and it is low before any such jump has executed.
- R9: While reset is high, the program counter, the accumulator, `parked` and `mem_we` are zero. After reset is released, the first fetch reads address 0.
- R10: A jump, store or increment takes two clock cycles and a load takes three. Every operation other than a jump advances the program counter by one.
- R11: A program can dispatch on a stored bit. It loads the bit, increments it, stores the result into a code slot and executes that slot. Control then reaches the slot's next word when the bit is 0, or the word after that when the bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Memory address for fetch, load or store |
| mem_wdata | output | DATA_W | Store data, which is the accumulator value |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the address |
| pc_dbg | output | ADDR_W | Current program counter |
| acc_dbg | output | DATA_W | Current accumulator |
| parked | output | 1 | A zero-offset jump has executed and is repeating |

## Verification
The hardest case to reach from the ports is a store that rewrites a code word which is fetched a few cycles later. This matters most when the new contents are a computed data value that then acts as a jump. The stimulus reaches this case with preloaded programs that load a tape bit, increment it, store it into an empty slot and run it. Both bit values are used, and each run must park at a different address. Another program overwrites a placeholder self-jump with an increment, so a store that does not land before the refetch leaves the core parked at the wrong address. Wrapping is reached through a negative offset from address 0, which points to the top of memory.

// File: rtl/rjc_pkg.sv
package rjc_pkg;

    typedef enum logic [1:0] {
        OP_JUMP  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_INC   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'b00,
        PH_EXEC   = 2'b01,
        PH_LDWAIT = 2'b10
    } phase_e;

    typedef struct packed {
        op_e  op;
        logic self_ref;
    } dec_t;

    typedef struct packed {
        logic pc_take;
        logic pc_step;
        logic acc_inc;
        logic acc_load;
        logic wr_en;
        logic addr_sel;
        logic park_set;
        logic park_clr;
    } ctrl_t;

    function automatic op_e op_field(input logic [1:0] bits);
        return op_e'(bits);
    endfunction

endpackage

// File: rtl/rjc_decode.sv
module rjc_decode
    import rjc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 10
) (
    input  logic [DATA_W-1:0] word,
    input  logic [ADDR_W-1:0] pc,
    output dec_t              dec,
    output logic [ADDR_W-1:0] ea
);
    localparam int OFS_W = DATA_W - 2;

    logic [OFS_W-1:0]  ofs;
    logic [ADDR_W-1:0] ofs_ext;

    assign ofs = word[OFS_W-1:0];

    generate
        if (OFS_W > ADDR_W) begin : g_trunc
            logic unused_ofs_hi;
            assign unused_ofs_hi = ^ofs[OFS_W-1:ADDR_W];
            assign ofs_ext = ofs[ADDR_W-1:0];
        end else if (OFS_W == ADDR_W) begin : g_same
            assign ofs_ext = ofs;
        end else begin : g_sext
            assign ofs_ext = {{(ADDR_W-OFS_W){ofs[OFS_W-1]}}, ofs};
        end
    endgenerate

    assign ea           = pc + ofs_ext;
    assign dec.op       = op_field(word[DATA_W-1 -: 2]);
    assign dec.self_ref = (ofs == '0);

endmodule

// File: rtl/rjc_fsm.sv
module rjc_fsm
    import rjc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  dec_t  dec,
    output ctrl_t ctrl
);
    phase_e phase_q, phase_d;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_FETCH;
        else     phase_q <= phase_d;
    end

    always_comb begin
        ctrl    = '0;
        phase_d = PH_FETCH;
        case (phase_q)
            PH_FETCH: begin
                phase_d = PH_EXEC;
            end
            PH_EXEC: begin
                case (dec.op)
                    OP_JUMP: begin
                        ctrl.pc_take  = 1'b1;
                        ctrl.park_set = dec.self_ref;
                        ctrl.park_clr = ~dec.self_ref;
                    end
                    OP_LOAD: begin
                        ctrl.addr_sel = 1'b1;
                        ctrl.pc_step  = 1'b1;
                        ctrl.park_clr = 1'b1;
                        phase_d       = PH_LDWAIT;
                    end
                    OP_STORE: begin
                        ctrl.addr_sel = 1'b1;
                        ctrl.wr_en    = 1'b1;
                        ctrl.pc_step  = 1'b1;
                        ctrl.park_clr = 1'b1;
                    end
                    default: begin
                        ctrl.acc_inc  = 1'b1;
                        ctrl.pc_step  = 1'b1;
                        ctrl.park_clr = 1'b1;
                    end
                endcase
            end
            PH_LDWAIT: begin
                ctrl.acc_load = 1'b1;
            end
            default: begin
                phase_d = PH_FETCH;
            end
        endcase
    end

endmodule

// File: rtl/rjc_regs.sv
module rjc_regs
    import rjc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [ADDR_W-1:0] ea,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc,
    output logic              park
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= '0;
            acc  <= '0;
            park <= 1'b0;
        end else begin
            if (ctrl.pc_take)      pc <= ea;
            else if (ctrl.pc_step) pc <= pc + ADDR_W'(1);

            if (ctrl.acc_load)     acc <= rdata;
            else if (ctrl.acc_inc) acc <= acc + DATA_W'(1);

            if (ctrl.park_set)      park <= 1'b1;
            else if (ctrl.park_clr) park <= 1'b0;
        end
    end

endmodule

// File: rtl/rjc_core.sv
module rjc_core
    import rjc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc_dbg,
    output logic [DATA_W-1:0] acc_dbg,
    output logic              parked
);
    dec_t              dec;
    ctrl_t             ctrl;
    logic [ADDR_W-1:0] ea;
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] acc;
    logic              park;

    rjc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .word (mem_rdata),
        .pc   (pc),
        .dec  (dec),
        .ea   (ea)
    );

    rjc_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .dec  (dec),
        .ctrl (ctrl)
    );

    rjc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .ea    (ea),
        .rdata (mem_rdata),
        .pc    (pc),
        .acc   (acc),
        .park  (park)
    );

    assign mem_addr  = ctrl.addr_sel ? ea : pc;
    assign mem_wdata = acc;
    assign mem_we    = ctrl.wr_en;
    assign pc_dbg    = pc;
    assign acc_dbg   = acc;
    assign parked    = park;

endmodule

// File: rtl/rjc_checker.sv
module rjc_checker #(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic [ADDR_W-1:0] pc_dbg,
    input logic [DATA_W-1:0] acc_dbg,
    input logic              parked
);
    logic unused_chk;
    assign unused_chk = ^mem_addr;

    // R9: reset clears the visible state
    p_reset_clears_r9: assert property (@(posedge clk)
        rst |=> (pc_dbg == '0 && acc_dbg == '0 && !parked && !mem_we));

    // R5: a write strobe never lasts more than one cycle
    p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R5: the accumulator is not disturbed by a store
    p_we_acc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> $stable(acc_dbg));

    // R10: at least two cycles separate program counter updates
    p_pc_spacing_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc_dbg) |=> $stable(pc_dbg));

    // R8: once parked, the core stays put
    p_park_hold_r8: assert property (@(posedge clk) disable iff (rst)
        parked |=> (parked && $stable(pc_dbg) && $stable(acc_dbg)));

endmodule

bind rjc_core rjc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .pc_dbg   (pc_dbg),
    .acc_dbg  (acc_dbg),
    .parked   (parked)
);

// File: tb/rjc_core_bench.sv
`timescale 1ns/1ps
module rjc_core_bench;
    localparam int DW    = 12;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int NV    = 10;
    localparam int VW    = 170;

    // {w7..w0, aux_addr, aux_val, exp_pc, exp_acc, chk_addr, chk_val, exp_cyc}
    localparam logic [VW-1:0] VECS [0:NV-1] = '{
        // R1 R6 R10: increments, one with a nonzero offset field
        {12'h000,12'h000,12'h000,12'h000,12'h000,12'hC00,12'hC3F,12'hC00,
         10'h3F0,12'h000, 10'h003,12'h003, 10'h001,12'hC3F, 8'd8},
        // R4 R5: load, increment, store
        {12'h000,12'h000,12'h000,12'h07F,12'h000,12'h803,12'hC00,12'h404,
         10'h3F0,12'h000, 10'h003,12'h080, 10'h005,12'h080, 8'd9},
        // R2 R4: negative offset wraps to top of memory
        {12'h000,12'h000,12'h000,12'h000,12'h000,12'h000,12'h000,12'h7FF,
         10'h3FF,12'h123, 10'h001,12'h123, 10'h3FF,12'h123, 8'd5},
        // R3 R2: forward and backward jumps
        {12'h000,12'h000,12'h000,12'h3FD,12'hC00,12'h000,12'hC00,12'h003,
         10'h3F0,12'h000, 10'h002,12'h002, 10'h000,12'h003, 8'd10},
        // R6: accumulator wraps
        {12'h000,12'h000,12'h000,12'h000,12'hFFF,12'h000,12'hC00,12'h403,
         10'h3F0,12'h000, 10'h002,12'h000, 10'h003,12'hFFF, 8'd7},
        // R3: data word 1 runs as jump to next word
        {12'h000,12'h000,12'h000,12'h000,12'h000,12'h000,12'hC00,12'h001,
         10'h3F0,12'h000, 10'h002,12'h001, 10'h000,12'h001, 8'd6},
        // R7 R5: store overwrites a placeholder self-jump
        {12'h000,12'h000,12'h000,12'hC00,12'h000,12'h000,12'h801,12'h404,
         10'h3F0,12'h000, 10'h003,12'hC01, 10'h002,12'hC00, 8'd9},
        // R11: dispatch on tape bit 0
        {12'h000,12'h000,12'h000,12'h000,12'h000,12'h801,12'hC00,12'h406,
         10'h3F0,12'h000, 10'h004,12'h001, 10'h003,12'h001, 8'd11},
        // R11: dispatch on tape bit 1
        {12'h000,12'h001,12'h000,12'h000,12'h000,12'h801,12'hC00,12'h406,
         10'h3F0,12'h000, 10'h005,12'h002, 10'h003,12'h002, 8'd11},
        // R2 R3 R8: jump wraps below address 0
        {12'h000,12'h000,12'h000,12'h000,12'h000,12'h000,12'h000,12'h3FE,
         10'h3FE,12'hC00, 10'h3FF,12'h001, 10'h3FE,12'hC00, 8'd6}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] pc_dbg;
    logic [DW-1:0] acc_dbg;
    logic          parked;

    logic          ld_we   = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [DW-1:0] mem [0:DEPTH-1];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            if (ld_we) mem[ld_addr] <= ld_data;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
    end

    rjc_core #(.DATA_W(DW), .ADDR_W(AW)) u_rjc_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .pc_dbg    (pc_dbg),
        .acc_dbg   (acc_dbg),
        .parked    (parked)
    );

    function automatic string vtag(input int i);
        case (i)
            0: return "R1 R6 R10";
            1: return "R4 R5";
            2: return "R2 R4";
            3: return "R3 R2";
            4: return "R6";
            5: return "R3";
            6: return "R7 R5";
            7: return "R11";
            8: return "R11";
            default: return "R2 R3";
        endcase
    endfunction

    function automatic int stores_of(input int i);
        return (i == 1 || i == 6 || i == 7 || i == 8) ? 1 : 0;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_vec(input logic [VW-1:0] v);
        rst = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            ld_we = 1'b1; ld_addr = AW'(a); ld_data = '0;
            @(negedge clk);
        end
        for (int w = 0; w < 8; w++) begin
            ld_addr = AW'(w); ld_data = v[74 + 12*w +: 12];
            @(negedge clk);
        end
        ld_addr = v[73:64]; ld_data = v[63:52];
        @(negedge clk);
        ld_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(output int cyc, output int wes);
        cyc = 0; wes = 0;
        rst = 1'b0;
        while (!parked && cyc < 300) begin
            @(negedge clk);
            cyc++;
            if (mem_we) wes++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog: actual=expired expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc, wes;
        // R9: reset state while held in reset
        load_vec(VECS[0]);
        check("R9", "pc in reset", 32'(pc_dbg), 0);
        check("R9", "acc in reset", 32'(acc_dbg), 0);
        check("R9", "parked in reset", 32'(parked), 0);
        check("R9", "we in reset", 32'(mem_we), 0);
        check("R9", "first fetch address", 32'(mem_addr), 0);

        for (int i = 0; i < NV; i++) begin
            string t;
            t = vtag(i);
            load_vec(VECS[i]);
            run(cyc, wes);
            check(t, $sformatf("v%0d R10 cycles", i), 32'(cyc), 32'(VECS[i][7:0]));
            check(t, $sformatf("v%0d R8 parked", i), 32'(parked), 1);
            check(t, $sformatf("v%0d pc", i), 32'(pc_dbg), 32'(VECS[i][51:42]));
            check(t, $sformatf("v%0d acc", i), 32'(acc_dbg), 32'(VECS[i][41:30]));
            check(t, $sformatf("v%0d memory", i),
                  32'(mem[VECS[i][29:20]]), 32'(VECS[i][19:8]));
            check(t, $sformatf("v%0d R5 store strobes", i), 32'(wes), 32'(stores_of(i)));
        end

        // R8: parked holds while the self-jump repeats
        load_vec(VECS[3]);
        run(cyc, wes);
        repeat (10) @(negedge clk);
        check("R8", "parked held", 32'(parked), 1);
        check("R8", "pc held", 32'(pc_dbg), 2);

        // R9: reset in the middle of a run
        load_vec(VECS[0]);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R9", "acc before mid reset", 32'(acc_dbg), 2);
        rst = 1'b1;
        @(negedge clk);
        check("R9", "pc after mid reset", 32'(pc_dbg), 0);
        check("R9", "acc after mid reset", 32'(acc_dbg), 0);
        check("R9", "parked after mid reset", 32'(parked), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule